// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

This block is a 1024 x 8 memory with two independent access ports, left and right. Two processors can share it. Each port has its own active-low chip enable, write enable and output enable, a 10-bit address, a data input, a data output and an output-valid flag. Both ports run on one shared clock. A read is registered, so its data shows up one clock after the address is presented.

The two highest locations are mailboxes as well as ordinary storage. A left-port write to the top location (0x3FF) raises the right port's interrupt. A right-port access that reads that location drops the interrupt again. The location one below the top (0x3FE) does the same job in the other direction. It raises the left interrupt on a right-port write and drops it on a left-port read.

Each port also has an active-low busy input, driven by an outside arbiter. While a port's busy input is low, that port cannot write, set a flag or clear a flag.

Top module: `dpram_mbox`

## Requirements
- R1: While rst_n is low and after its release, both interrupt outputs are high, both output-valid flags are low and both data outputs are zero.
- R2: At a clock edge where a port has ce_n=0, we_n=0 and busy_n=1, its data input is stored at its address. The same access with busy_n=0 leaves the location unchanged.
- R3: At a clock edge where a port has ce_n=0, we_n=1 and oe_n=0, the port's data output takes the word its address held before any write at that edge, and its valid flag goes high. For any other control combination the valid flag goes low and the data output holds.
- R4: A left-port write to 0x3FF with l_busy_n=1 drives r_int_n low after the edge. A right-port access with r_ce_n=0, r_oe_n=0, r_busy_n=1 and address 0x3FF drives r_int_n high after the edge. The data written at 0x3FF is stored like any other word.
- R5: A right-port write to 0x3FE with r_busy_n=1 drives l_int_n low after the edge. A left-port access with l_ce_n=0, l_oe_n=0, l_busy_n=1 and address 0x3FE drives l_int_n high after the edge.
- R6: When the acting port's busy input is low, the mailbox set or clear it would cause does not happen, and the flag keeps its level.
- R7: When one edge carries both the set and the clear of the same interrupt flag, the flag ends set (low).
- R8: When both ports write the same address at the same edge, the left port's data is stored.
- R9: A port with ce_n=1 performs no write, no read and no mailbox action, whatever its we_n, oe_n and address are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy, active low; blocks left writes and mailbox actions |
| l_addr | input | 10 | Left address |
| l_din | input | 8 | Left write data |
| l_dout | output | 8 | Left registered read data |
| l_dout_vld | output | 1 | Left read data valid |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy, active low; blocks right writes and mailbox actions |
| r_addr | input | 10 | Right address |
| r_din | input | 8 | Right write data |
| r_dout | output | 8 | Right registered read data |
| r_dout_vld | output | 1 | Right read data valid |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The properties assume that every control input is at a known level at each rising edge once reset is released. They also assume that the busy inputs are plain levels supplied from outside, with no arbitration logic modelled inside the block. The stimulus changes inputs only on the falling edge, and it holds every control line at a defined value from time zero. The bench never checks read data in a cycle where that port's busy input is low, because the data is not promised to be valid there.

// File: rtl/dpram_mbox_pkg.sv
package dpram_mbox_pkg;
    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic busy_n;
    } port_ctl_t;
endpackage

// File: rtl/mbx_mem.sv
module mbx_mem
    import dpram_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic                               clk,
    input  logic [NUM_PORTS-1:0]               wr_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]   wr_data,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Highest index applied first, so port 0 (left) lands last and wins.
    always_ff @(posedge clk) begin
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (wr_en[i]) begin
                mem_q[addr[i]] <= wr_data[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
        assign rd_data[g] = mem_q[addr[g]];
    end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import dpram_mbox_pkg::*;
#(
    parameter int unsigned            ADDR_W   = 10,
    parameter int unsigned            DATA_W   = 8,
    parameter logic [ADDR_W-1:0]      OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0]      PEER_BOX = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic              peer_set,
    output logic              own_clr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);
    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              vld;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      rd_req;

    always_comb begin
        rd_req   = !ctl.ce_n && ctl.we_n && !ctl.oe_n;
        wr_en    = !ctl.ce_n && !ctl.we_n && ctl.busy_n;
        peer_set = wr_en && (addr == PEER_BOX);
        own_clr  = !ctl.ce_n && !ctl.oe_n && ctl.busy_n && (addr == OWN_BOX);

        st_d     = st_q;
        st_d.vld = rd_req;
        if (rd_req) begin
            st_d.dout = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout     = st_q.dout;
    assign dout_vld = st_q.vld;
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic int_n
);
    typedef struct packed {
        logic pend;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.pend = 1'b1;
        end else if (clr) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_n = !st_q.pend;
endmodule

// File: rtl/dpram_mbox.sv
module dpram_mbox
    import dpram_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_busy_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_dout_vld,
    output logic              l_int_n,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_busy_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_dout_vld,
    output logic              r_int_n
);
    localparam int unsigned       DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] BOX_L  = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] BOX_R  = ADDR_W'(DEPTH - 1);

    port_ctl_t [NUM_PORTS-1:0]             ctl;
    logic      [NUM_PORTS-1:0][ADDR_W-1:0] addr;
    logic      [NUM_PORTS-1:0][DATA_W-1:0] din;
    logic      [NUM_PORTS-1:0][DATA_W-1:0] rdata;
    logic      [NUM_PORTS-1:0][DATA_W-1:0] dout;
    logic      [NUM_PORTS-1:0]             wr_en;
    logic      [NUM_PORTS-1:0]             peer_set;
    logic      [NUM_PORTS-1:0]             own_clr;
    logic      [NUM_PORTS-1:0]             vld;
    logic      [NUM_PORTS-1:0]             int_n;

    assign ctl[PORT_L]  = '{ce_n: l_ce_n, we_n: l_we_n, oe_n: l_oe_n, busy_n: l_busy_n};
    assign ctl[PORT_R]  = '{ce_n: r_ce_n, we_n: r_we_n, oe_n: r_oe_n, busy_n: r_busy_n};
    assign addr[PORT_L] = l_addr;
    assign addr[PORT_R] = r_addr;
    assign din[PORT_L]  = l_din;
    assign din[PORT_R]  = r_din;

    mbx_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (din),
        .rd_data (rdata)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (g == PORT_L) ? BOX_L : BOX_R;
        localparam logic [ADDR_W-1:0] PEER = (g == PORT_L) ? BOX_R : BOX_L;
        localparam int unsigned       OTHER = NUM_PORTS - 1 - g;

        mbx_port #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl       (ctl[g]),
            .addr      (addr[g]),
            .mem_rdata (rdata[g]),
            .wr_en     (wr_en[g]),
            .peer_set  (peer_set[g]),
            .own_clr   (own_clr[g]),
            .dout      (dout[g]),
            .dout_vld  (vld[g])
        );

        mbx_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (peer_set[OTHER]),
            .clr   (own_clr[g]),
            .int_n (int_n[g])
        );
    end

    assign l_dout     = dout[PORT_L];
    assign r_dout     = dout[PORT_R];
    assign l_dout_vld = vld[PORT_L];
    assign r_dout_vld = vld[PORT_R];
    assign l_int_n    = int_n[PORT_L];
    assign r_int_n    = int_n[PORT_R];
endmodule

// File: rtl/dpram_mbox_chk.sv
module dpram_mbox_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_ce_n,
    input logic              l_we_n,
    input logic              l_oe_n,
    input logic              l_busy_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_dout,
    input logic              l_dout_vld,
    input logic              l_int_n,
    input logic              r_ce_n,
    input logic              r_we_n,
    input logic              r_oe_n,
    input logic              r_busy_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_dout,
    input logic              r_dout_vld,
    input logic              r_int_n
);
    localparam int unsigned       DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP   = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] NEXT  = ADDR_W'(DEPTH - 2);

    logic l_rd, r_rd, rflag_set, rflag_clr, lflag_set, lflag_clr;
    assign l_rd      = !l_ce_n && l_we_n && !l_oe_n;
    assign r_rd      = !r_ce_n && r_we_n && !r_oe_n;
    assign rflag_set = !l_ce_n && !l_we_n && l_busy_n && (l_addr == TOP);
    assign rflag_clr = !r_ce_n && !r_oe_n && r_busy_n && (r_addr == TOP);
    assign lflag_set = !r_ce_n && !r_we_n && r_busy_n && (r_addr == NEXT);
    assign lflag_clr = !l_ce_n && !l_oe_n && l_busy_n && (l_addr == NEXT);

    p_lvld_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd |=> l_dout_vld);
    p_lidle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> (!l_dout_vld && $stable(l_dout)));
    p_rvld_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_rd |=> r_dout_vld);
    p_ridle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> (!r_dout_vld && $stable(r_dout)));

    p_rint_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rflag_set |=> !r_int_n);
    p_rint_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rflag_clr && !rflag_set) |=> r_int_n);
    p_lint_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lflag_set |=> !l_int_n);
    p_lint_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lflag_clr && !lflag_set) |=> l_int_n);

    p_rint_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rflag_set && !rflag_clr) |=> $stable(r_int_n));
    p_lint_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lflag_set && !lflag_clr) |=> $stable(l_int_n));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rflag_set && rflag_clr) |=> !r_int_n);
endmodule

bind dpram_mbox dpram_mbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .l_ce_n     (l_ce_n),
    .l_we_n     (l_we_n),
    .l_oe_n     (l_oe_n),
    .l_busy_n   (l_busy_n),
    .l_addr     (l_addr),
    .l_dout     (l_dout),
    .l_dout_vld (l_dout_vld),
    .l_int_n    (l_int_n),
    .r_ce_n     (r_ce_n),
    .r_we_n     (r_we_n),
    .r_oe_n     (r_oe_n),
    .r_busy_n   (r_busy_n),
    .r_addr     (r_addr),
    .r_dout     (r_dout),
    .r_dout_vld (r_dout_vld),
    .r_int_n    (r_int_n)
);

// File: tb/dpram_mbox_test.sv
module dpram_mbox_test;
    localparam int CLK_PERIOD = 10;

    // op codes: 0 idle (ce high), 1 write, 2 read, 3 ce high with we/oe low
    typedef struct packed {
        logic [3:0] req;
        logic [1:0] lop;
        logic [9:0] la;
        logic [7:0] ld;
        logic [1:0] rop;
        logic [9:0] ra;
        logic [7:0] rd;
        logic [7:0] eld;
        logic [7:0] erd;
        logic       eli;
        logic       eri;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{4'd2, 2'd1, 10'h010, 8'hA5, 2'd0, 10'h000, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1}, // R2
        '{4'd2, 2'd0, 10'h000, 8'h00, 2'd1, 10'h020, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b1}, // R2
        '{4'd2, 2'd0, 10'h000, 8'h00, 2'd1, 10'h030, 8'h5A, 8'h00, 8'h00, 1'b1, 1'b1}, // R2
        '{4'd3, 2'd2, 10'h020, 8'h00, 2'd2, 10'h010, 8'h00, 8'h3C, 8'hA5, 1'b1, 1'b1}, // R3
        '{4'd4, 2'd1, 10'h3FF, 8'h77, 2'd0, 10'h000, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0}, // R4 set
        '{4'd4, 2'd0, 10'h000, 8'h00, 2'd2, 10'h3FF, 8'h00, 8'h00, 8'h77, 1'b1, 1'b1}, // R4 clear
        '{4'd5, 2'd0, 10'h000, 8'h00, 2'd1, 10'h3FE, 8'h11, 8'h00, 8'h00, 1'b0, 1'b1}, // R5 set
        '{4'd5, 2'd2, 10'h3FE, 8'h00, 2'd0, 10'h000, 8'h00, 8'h11, 8'h00, 1'b1, 1'b1}, // R5 clear
        '{4'd3, 2'd1, 10'h030, 8'hC3, 2'd2, 10'h030, 8'h00, 8'h00, 8'h5A, 1'b1, 1'b1}, // R3 old data
        '{4'd3, 2'd0, 10'h000, 8'h00, 2'd2, 10'h030, 8'h00, 8'h00, 8'hC3, 1'b1, 1'b1}, // R3
        '{4'd8, 2'd1, 10'h040, 8'h01, 2'd1, 10'h040, 8'h02, 8'h00, 8'h00, 1'b1, 1'b1}, // R8
        '{4'd8, 2'd2, 10'h040, 8'h00, 2'd0, 10'h000, 8'h00, 8'h01, 8'h00, 1'b1, 1'b1}, // R8
        '{4'd7, 2'd1, 10'h3FF, 8'h99, 2'd2, 10'h3FF, 8'h00, 8'h00, 8'h77, 1'b1, 1'b0}, // R7
        '{4'd7, 2'd0, 10'h000, 8'h00, 2'd2, 10'h3FF, 8'h00, 8'h00, 8'h99, 1'b1, 1'b1}, // R7
        '{4'd9, 2'd3, 10'h010, 8'hFF, 2'd3, 10'h3FE, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1}, // R9
        '{4'd9, 2'd2, 10'h010, 8'h00, 2'd0, 10'h000, 8'h00, 8'hA5, 8'h00, 1'b1, 1'b1}  // R9
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_ce_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
    logic [9:0] l_addr = '0;
    logic [7:0] l_din = '0;
    logic       r_ce_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
    logic [9:0] r_addr = '0;
    logic [7:0] r_din = '0;
    logic [7:0] l_dout, r_dout;
    logic       l_dout_vld, r_dout_vld, l_int_n, r_int_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = !clk;

    dpram_mbox uut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
        .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_dout_vld(l_dout_vld),
        .l_int_n(l_int_n),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
        .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_dout_vld(r_dout_vld),
        .r_int_n(r_int_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_l(input logic [1:0] op, input logic [9:0] a,
                           input logic [7:0] d, input logic busy_n);
        l_ce_n   = !(op == 2'd1 || op == 2'd2);
        l_we_n   = !(op == 2'd1 || op == 2'd3);
        l_oe_n   = !(op == 2'd2 || op == 2'd3);
        l_addr   = a;
        l_din    = d;
        l_busy_n = busy_n;
    endtask

    task automatic drive_r(input logic [1:0] op, input logic [9:0] a,
                           input logic [7:0] d, input logic busy_n);
        r_ce_n   = !(op == 2'd1 || op == 2'd2);
        r_we_n   = !(op == 2'd1 || op == 2'd3);
        r_oe_n   = !(op == 2'd2 || op == 2'd3);
        r_addr   = a;
        r_din    = d;
        r_busy_n = busy_n;
    endtask

    // Inputs applied on the falling edge; outputs sampled a quarter period after the rising edge.
    task automatic cycle();
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    task automatic idle_both();
        @(negedge clk);
        drive_l(2'd0, '0, '0, 1'b1);
        drive_r(2'd0, '0, '0, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD / 4);
        // R1: state during reset
        chk("R1", "l_int_n in reset", {7'd0, l_int_n}, 8'd1);
        chk("R1", "r_int_n in reset", {7'd0, r_int_n}, 8'd1);
        @(negedge clk);
        rst_n = 1'b1;
        cycle();
        // R1: state after release
        chk("R1", "l_dout_vld", {7'd0, l_dout_vld}, 8'd0);
        chk("R1", "r_dout_vld", {7'd0, r_dout_vld}, 8'd0);
        chk("R1", "l_dout", l_dout, 8'h00);
        chk("R1", "r_dout", r_dout, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive_l(VEC[i].lop, VEC[i].la, VEC[i].ld, 1'b1);
            drive_r(VEC[i].rop, VEC[i].ra, VEC[i].rd, 1'b1);
            cycle();
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            chk(tag, "l_dout_vld", {7'd0, l_dout_vld}, {7'd0, VEC[i].lop == 2'd2});
            chk(tag, "r_dout_vld", {7'd0, r_dout_vld}, {7'd0, VEC[i].rop == 2'd2});
            if (VEC[i].lop == 2'd2) chk(tag, "l_dout", l_dout, VEC[i].eld);
            if (VEC[i].rop == 2'd2) chk(tag, "r_dout", r_dout, VEC[i].erd);
            chk(tag, "l_int_n", {7'd0, l_int_n}, {7'd0, VEC[i].eli});
            chk(tag, "r_int_n", {7'd0, r_int_n}, {7'd0, VEC[i].eri});
        end

        // R3: data output holds across idle cycles after a read
        idle_both();
        cycle();
        chk("R3", "l_dout hold", l_dout, 8'hA5);
        chk("R3", "l_dout_vld idle", {7'd0, l_dout_vld}, 8'd0);

        // R2: busy write is blocked
        @(negedge clk); drive_l(2'd1, 10'h050, 8'h55, 1'b1); cycle();
        @(negedge clk); drive_l(2'd1, 10'h050, 8'hAA, 1'b0); cycle();
        @(negedge clk); drive_l(2'd2, 10'h050, 8'h00, 1'b1); cycle();
        chk("R2", "busy write blocked", l_dout, 8'h55);

        // R6: busy left write to 0x3FF does not set right flag
        @(negedge clk); drive_l(2'd1, 10'h3FF, 8'h12, 1'b0); cycle();
        chk("R6", "r_int_n busy set", {7'd0, r_int_n}, 8'd1);
        // set it properly, then attempt a busy clear
        @(negedge clk); drive_l(2'd1, 10'h3FF, 8'h34, 1'b1); cycle();
        chk("R4", "r_int_n set", {7'd0, r_int_n}, 8'd0);
        @(negedge clk); drive_l(2'd0, '0, '0, 1'b1); drive_r(2'd2, 10'h3FF, '0, 1'b0); cycle();
        chk("R6", "r_int_n busy clear", {7'd0, r_int_n}, 8'd0);
        // R6: busy right write to 0x3FE does not set left flag
        @(negedge clk); drive_r(2'd1, 10'h3FE, 8'h56, 1'b0); cycle();
        chk("R6", "l_int_n busy set", {7'd0, l_int_n}, 8'd1);
        @(negedge clk); drive_r(2'd2, 10'h3FF, '0, 1'b1); cycle();
        chk("R4", "r_int_n clear", {7'd0, r_int_n}, 8'd1);
        chk("R4", "mailbox data", r_dout, 8'h34);

        // R1: reset mid-run returns flags to inactive
        @(negedge clk); drive_r(2'd1, 10'h3FE, 8'h78, 1'b1); cycle();
        chk("R5", "l_int_n set", {7'd0, l_int_n}, 8'd0);
        @(negedge clk); drive_r(2'd2, 10'h3FE, '0, 1'b1); rst_n = 1'b0; cycle();
        chk("R1", "l_int_n after reset", {7'd0, l_int_n}, 8'd1);
        chk("R1", "r_dout_vld after reset", {7'd0, r_dout_vld}, 8'd0);
        chk("R1", "r_dout after reset", r_dout, 8'h00);

        idle_both();
        rst_n = 1'b1;
        cycle();
        finish_run();
    end
endmodule